// File: doc/BRIEF.md
# I2C Target Single-Byte Register Writer

This block is the write side of an I2C target. It watches the open-drain clock and data lines of the bus. It recognises bus start and stop conditions and checks the 7-bit target address that opens each transaction. It then accepts a register pointer byte followed by exactly one data byte. When the pointer names an implemented register that the write mask marks as writable, the data byte is acknowledged and stored in a small register file.

Every other data byte is refused with a NACK and has no effect. This covers read-only registers, pointers past the end of the map, and any byte that follows the single data byte. The register contents are exposed as one flat vector for neighbouring logic.

Each accepted write is also reported on a valid-only write port: `wr_stb` qualifies `wr_idx` and `wr_data` for exactly one cycle. The port has no ready and takes no back-pressure, because a consumer that falls behind must not stall the bus. The register file itself is updated on the cycle after the strobe.

Top module: `i2c_reg_writer`

## Requirements
- R1: After reset, `sda_oe` and `wr_stb` are low, and every register holds its `REG_INIT` slice (register i at bits [8i+7:8i]).
- R2: An address byte whose upper seven bits equal `TGT_ADDR` and whose last bit (R/W) is 0 is acknowledged: `sda_oe` is high while SCL is high during the ninth clock.
- R3: An address byte with a different address, or with R/W = 1, is not acknowledged. SDA then stays released for every following byte until the next START, and no register changes.
- R4: The first byte after an acknowledged address is the register pointer, and it is always acknowledged.
- R5: The second byte is the data byte. If the pointer is below `NUM_REGS` and `WR_MASK[pointer]` is 1, the data byte is acknowledged, `wr_stb` pulses with `wr_idx` = pointer and `wr_data` = data, and the register then holds the data.
- R6: A data byte aimed at a register whose `WR_MASK` bit is 0 is NACKed, produces no strobe, and leaves every register unchanged.
- R7: A data byte aimed at a pointer of `NUM_REGS` or above is NACKed, produces no strobe, and leaves every register unchanged.
- R8: Any byte after the single data byte is NACKed and changes no register.
- R9: A START inside a transaction restarts address reception, so a complete write after a repeated START takes effect.
- R10: A STOP at any point returns the block to idle. A data byte cut short by a STOP writes nothing.
- R11: `sda_oe` changes only while SCL is low.
- R12: `wr_stb` is high for exactly one clock cycle per accepted write, and a register changes only on the cycle after such a strobe.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line as seen on the pad |
| sda_i | input | 1 | Bus data line as seen on the pad |
| sda_oe | output | 1 | High to pull SDA low (ACK) |
| reg_flat | output | 8*NUM_REGS | All register contents, register i at bits [8i+7:8i] |
| wr_stb | output | 1 | One-cycle valid for an accepted write |
| wr_idx | output | IDX_W | Register index of the accepted write |
| wr_data | output | 8 | Data byte of the accepted write |

## Verification
The assertions assume a well-behaved bus controller, with three guarantees. SCL stays in each level for many system clocks, so the synchronised edges arrive well before the next bus event. SDA moves only while SCL is low, except when it forms a START or a STOP. And the controller never tries to signal START or STOP while the target holds SDA low. The bench drives the bus from tasks that use a quarter-bit of ten system clocks. Those tasks change SDA only in the low phase of SCL, or in the dedicated start and stop sequences. They release SDA during every acknowledge bit, which keeps all stimulus inside those assumptions.

// File: rtl/i2cw_pkg.sv
package i2cw_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RX,
    ST_ACK_WAIT,
    ST_ACK,
    ST_IGNORE
  } state_e;

  typedef enum logic [1:0] {
    PH_ADDR,
    PH_PTR,
    PH_DATA,
    PH_EXTRA
  } phase_e;
endpackage

// File: rtl/i2cw_sync.sv
module i2cw_sync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det,
  output logic sda_bit
);
  localparam int PIPE = SYNC_STAGES + 1;

  logic [PIPE-1:0] scl_p, sda_p;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_p <= '1;
      sda_p <= '1;
    end else begin
      scl_p <= {scl_p[PIPE-2:0], scl_i};
      sda_p <= {sda_p[PIPE-2:0], sda_i};
    end
  end

  // stage SYNC_STAGES-1 is the synchronized value, stage PIPE-1 its previous cycle
  logic scl_s, scl_d, sda_s, sda_d;
  assign scl_s = scl_p[SYNC_STAGES-1];
  assign scl_d = scl_p[PIPE-1];
  assign sda_s = sda_p[SYNC_STAGES-1];
  assign sda_d = sda_p[PIPE-1];

  assign scl_rise  = scl_s & ~scl_d;
  assign scl_fall  = ~scl_s & scl_d;
  assign start_det = scl_s & scl_d & sda_d & ~sda_s;
  assign stop_det  = scl_s & scl_d & ~sda_d & sda_s;
  assign sda_bit   = sda_s;
endmodule

// File: rtl/i2cw_ctrl.sv
module i2cw_ctrl
  import i2cw_pkg::*;
#(
  parameter logic [6:0]          TGT_ADDR = 7'h48,
  parameter int                  NUM_REGS = 8,
  parameter int                  IDX_W    = 3,
  parameter logic [NUM_REGS-1:0] WR_MASK  = '1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             scl_rise,
  input  logic             scl_fall,
  input  logic             start_det,
  input  logic             stop_det,
  input  logic             sda_bit,
  output logic             sda_oe,
  output logic             wr_stb,
  output logic [IDX_W-1:0] wr_idx,
  output logic [7:0]       wr_data
);
  localparam logic [8:0]   NREG9   = 9'(NUM_REGS);
  localparam logic [255:0] MASK256 = 256'(WR_MASK);

  state_e     state;
  phase_e     phase;
  logic [2:0] bitcnt;
  logic [6:0] shreg;
  logic [7:0] ptr;
  logic [7:0] byte_now;
  logic       ptr_ok;

  assign byte_now = {shreg, sda_bit};
  assign ptr_ok   = ({1'b0, ptr} < NREG9) && MASK256[ptr];
  assign sda_oe   = (state == ST_ACK);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      phase   <= PH_ADDR;
      bitcnt  <= '0;
      shreg   <= '0;
      ptr     <= '0;
      wr_stb  <= 1'b0;
      wr_idx  <= '0;
      wr_data <= '0;
    end else begin
      wr_stb <= 1'b0;
      if (start_det) begin
        state  <= ST_RX;
        phase  <= PH_ADDR;
        bitcnt <= '0;
      end else if (stop_det) begin
        state <= ST_IDLE;
      end else begin
        case (state)
          ST_RX: if (scl_rise) begin
            shreg  <= byte_now[6:0];
            bitcnt <= bitcnt + 3'd1;
            if (bitcnt == 3'd7) begin
              case (phase)
                PH_ADDR: begin
                  if (byte_now[7:1] == TGT_ADDR && !byte_now[0]) begin
                    state <= ST_ACK_WAIT;
                    phase <= PH_PTR;
                  end else begin
                    state <= ST_IGNORE;
                  end
                end
                PH_PTR: begin
                  ptr   <= byte_now;
                  state <= ST_ACK_WAIT;
                  phase <= PH_DATA;
                end
                PH_DATA: begin
                  if (ptr_ok) begin
                    wr_stb  <= 1'b1;
                    wr_idx  <= ptr[IDX_W-1:0];
                    wr_data <= byte_now;
                    state   <= ST_ACK_WAIT;
                    phase   <= PH_EXTRA;
                  end else begin
                    state <= ST_IGNORE;
                  end
                end
                default: state <= ST_IGNORE;
              endcase
            end
          end
          ST_ACK_WAIT: if (scl_fall) state <= ST_ACK;
          ST_ACK: if (scl_fall) begin
            state  <= ST_RX;
            bitcnt <= '0;
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/i2cw_regs.sv
module i2cw_regs #(
  parameter int                    NUM_REGS = 8,
  parameter int                    IDX_W    = 3,
  parameter logic [NUM_REGS-1:0]   WR_MASK  = '1,
  parameter logic [NUM_REGS*8-1:0] REG_INIT = '0
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  we,
  input  logic [IDX_W-1:0]      widx,
  input  logic [7:0]            wdata,
  output logic [NUM_REGS*8-1:0] reg_flat
);
  for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
    if (WR_MASK[i]) begin : g_rw
      logic [7:0] q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                            q <= REG_INIT[i*8 +: 8];
        else if (we && widx == IDX_W'(i))      q <= wdata;
      end
      assign reg_flat[i*8 +: 8] = q;
    end else begin : g_ro
      assign reg_flat[i*8 +: 8] = REG_INIT[i*8 +: 8];
    end
  end
endmodule

// File: rtl/i2c_reg_writer.sv
module i2c_reg_writer #(
  parameter logic [6:0]            TGT_ADDR    = 7'h48,
  parameter int                    NUM_REGS    = 8,
  parameter logic [NUM_REGS-1:0]   WR_MASK     = 8'hF6,
  parameter logic [NUM_REGS*8-1:0] REG_INIT    = '0,
  parameter int                    SYNC_STAGES = 2,
  localparam int                   IDX_W       = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  scl_i,
  input  logic                  sda_i,
  output logic                  sda_oe,
  output logic [NUM_REGS*8-1:0] reg_flat,
  output logic                  wr_stb,
  output logic [IDX_W-1:0]      wr_idx,
  output logic [7:0]            wr_data
);
  logic scl_rise, scl_fall, start_det, stop_det, sda_bit;

  i2cw_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
    .clk       (clk),
    .rst_n     (rst_n),
    .scl_i     (scl_i),
    .sda_i     (sda_i),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .start_det (start_det),
    .stop_det  (stop_det),
    .sda_bit   (sda_bit)
  );

  i2cw_ctrl #(
    .TGT_ADDR (TGT_ADDR),
    .NUM_REGS (NUM_REGS),
    .IDX_W    (IDX_W),
    .WR_MASK  (WR_MASK)
  ) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .start_det (start_det),
    .stop_det  (stop_det),
    .sda_bit   (sda_bit),
    .sda_oe    (sda_oe),
    .wr_stb    (wr_stb),
    .wr_idx    (wr_idx),
    .wr_data   (wr_data)
  );

  i2cw_regs #(
    .NUM_REGS (NUM_REGS),
    .IDX_W    (IDX_W),
    .WR_MASK  (WR_MASK),
    .REG_INIT (REG_INIT)
  ) u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .we       (wr_stb),
    .widx     (wr_idx),
    .wdata    (wr_data),
    .reg_flat (reg_flat)
  );
endmodule

// File: rtl/i2cw_checker.sv
module i2cw_checker #(
  parameter int                  NUM_REGS = 8,
  parameter int                  IDX_W    = 3,
  parameter logic [NUM_REGS-1:0] WR_MASK  = '1
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  scl_i,
  input logic                  sda_oe,
  input logic [NUM_REGS*8-1:0] reg_flat,
  input logic                  wr_stb,
  input logic [IDX_W-1:0]      wr_idx,
  input logic [7:0]            wr_data
);
  localparam logic [255:0] MASK256 = 256'(WR_MASK);

  // R11: the target only moves SDA while the bus clock is low
  a_r11_oe_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_oe) |-> !scl_i);

  // R12: the write strobe never lasts longer than one cycle
  a_r12_stb_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb |=> !wr_stb);

  // R5: a strobe only ever names an implemented writable register
  a_r5_stb_writable: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb |-> (32'(wr_idx) < NUM_REGS) && MASK256[wr_idx]);

  for (genvar i = 0; i < NUM_REGS; i++) begin : g_chk
    if (WR_MASK[i]) begin : g_rw
      // R5: the strobed data lands in the addressed register
      a_r5_reg_follows: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(wr_stb) && $past(wr_idx) == IDX_W'(i)) |-> reg_flat[i*8 +: 8] == $past(wr_data));
      // R12: a register changes only right after a strobe naming it
      a_r12_no_stray_update: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(reg_flat[i*8 +: 8]) |-> ($past(wr_stb) && $past(wr_idx) == IDX_W'(i)));
    end else begin : g_ro
      // R6: read-only registers never change
      a_r6_ro_stable: assert property (@(posedge clk) disable iff (!rst_n)
        $stable(reg_flat[i*8 +: 8]));
    end
  end
endmodule

bind i2c_reg_writer i2cw_checker #(
  .NUM_REGS (NUM_REGS),
  .IDX_W    (IDX_W),
  .WR_MASK  (WR_MASK)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .scl_i    (scl_i),
  .sda_oe   (sda_oe),
  .reg_flat (reg_flat),
  .wr_stb   (wr_stb),
  .wr_idx   (wr_idx),
  .wr_data  (wr_data)
);

// File: tb/test_i2c_reg_writer.sv
`timescale 1ns/1ps
module test_i2c_reg_writer;
  localparam logic [6:0]  TGT   = 7'h48;
  localparam int          NR    = 8;
  localparam logic [7:0]  MASK  = 8'hF6;            // registers 0 and 3 read-only
  localparam logic [63:0] INIT  = 64'h0000_0000_5A00_003C;
  localparam int          Q     = 10;               // quarter bit in system clocks
  localparam int          IW    = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_m = 1'b1, sda_m = 1'b1;
  logic sda_oe, wr_stb;
  logic [NR*8-1:0] reg_flat;
  logic [IW-1:0] wr_idx;
  logic [7:0] wr_data;

  always #2 clk = ~clk;   // 250 MHz

  i2c_reg_writer #(.TGT_ADDR(TGT), .NUM_REGS(NR), .WR_MASK(MASK), .REG_INIT(INIT)) i_i2c_reg_writer (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_m & ~sda_oe),
    .sda_oe(sda_oe), .reg_flat(reg_flat), .wr_stb(wr_stb), .wr_idx(wr_idx), .wr_data(wr_data));

  int checks = 0, errors = 0;
  int stb_cnt = 0, run = 0, max_run = 0, oe_bad = 0;
  logic [IW-1:0] last_idx;
  logic [7:0] last_data;
  logic oe_prev = 1'b0;
  logic [7:0] model [NR];
  bit done = 0;

  always @(posedge clk) begin
    if (rst_n) begin
      if (wr_stb) begin
        stb_cnt <= stb_cnt + 1; last_idx <= wr_idx; last_data <= wr_data;
        run <= run + 1; if (run + 1 > max_run) max_run <= run + 1;
      end else run <= 0;
      if (sda_oe != oe_prev && scl_m) oe_bad <= oe_bad + 1;
      oe_prev <= sda_oe;
    end
  end

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic qwait(); repeat (Q) @(negedge clk); endtask

  task automatic bus_start();
    sda_m = 1; qwait(); scl_m = 1; qwait(); sda_m = 0; qwait(); scl_m = 0; qwait();
  endtask

  task automatic bus_stop();
    sda_m = 0; qwait(); scl_m = 1; qwait(); sda_m = 1; qwait();
  endtask

  task automatic send_bit(input logic b);
    sda_m = b; qwait(); scl_m = 1; qwait(); qwait(); scl_m = 0; qwait();
  endtask

  task automatic send_byte(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) send_bit(b[i]);
    sda_m = 1; qwait(); scl_m = 1; qwait(); ack = sda_oe; qwait(); scl_m = 0; qwait();
  endtask

  function automatic logic [63:0] model_flat();
    logic [63:0] f;
    for (int i = 0; i < NR; i++) f[i*8 +: 8] = model[i];
    return f;
  endfunction

  // {addr byte, pointer, data, addr ack, pointer ack, data ack}
  typedef logic [26:0] vec_t;
  localparam int NV = 9;
  localparam vec_t VEC [NV] = '{
    {8'h90, 8'h01, 8'h5A, 3'b111},
    {8'h90, 8'h07, 8'hC3, 3'b111},
    {8'h90, 8'h00, 8'h11, 3'b110},
    {8'h90, 8'h03, 8'h22, 3'b110},
    {8'h90, 8'h08, 8'h33, 3'b110},
    {8'h90, 8'hFF, 8'h44, 3'b110},
    {8'h92, 8'h02, 8'h55, 3'b000},
    {8'h91, 8'h02, 8'h66, 3'b000},
    {8'h90, 8'h02, 8'h77, 3'b111}
  };

  initial begin
    logic a, b, c, d;
    int s0;
    for (int i = 0; i < NR; i++) model[i] = INIT[i*8 +: 8];
    repeat (5) @(negedge clk);
    // R1 reset state
    chk("R1 sda_oe", 64'(sda_oe), 64'd0);
    chk("R1 wr_stb", 64'(wr_stb), 64'd0);
    chk("R1 regs", reg_flat, INIT);
    rst_n = 1; qwait();
    chk("R1 regs after release", reg_flat, INIT);

    for (int v = 0; v < NV; v++) begin
      string tg;
      logic [7:0] ab, pb, db;
      logic ea, ep, ed;
      {ab, pb, db, ea, ep, ed} = VEC[v];
      if (!ea) tg = "R3";
      else if (ed) tg = "R5";
      else if (pb >= NR) tg = "R7";
      else tg = "R6";
      s0 = stb_cnt;
      bus_start();
      send_byte(ab, a); send_byte(pb, b); send_byte(db, c);
      bus_stop(); qwait();
      if (ed) model[pb[2:0]] = db;
      chk(ea ? "R2 address ack" : "R3 address ack", 64'(a), 64'(ea));
      chk(ea ? "R4 pointer ack" : "R3 pointer ack", 64'(b), 64'(ep));
      chk({tg, " data ack"}, 64'(c), 64'(ed));
      chk({tg, " regs"}, reg_flat, model_flat());
      chk({tg, " strobes"}, 64'(stb_cnt - s0), 64'(ed));
      if (ed) begin
        chk("R5 wr_idx", 64'(last_idx), 64'(pb[2:0]));
        chk("R5 wr_data", 64'(last_data), 64'(db));
      end
    end

    // R8: a second data byte is refused
    s0 = stb_cnt;
    bus_start(); send_byte(8'h90, a); send_byte(8'h04, b); send_byte(8'hAB, c); send_byte(8'hCD, d);
    bus_stop(); qwait();
    model[4] = 8'hAB;
    chk("R8 first data ack", 64'(c), 64'd1);
    chk("R8 extra byte nack", 64'(d), 64'd0);
    chk("R8 regs", reg_flat, model_flat());
    chk("R8 strobes", 64'(stb_cnt - s0), 64'd1);

    // R9: repeated START after the pointer restarts address reception
    bus_start(); send_byte(8'h90, a); send_byte(8'h05, b);
    bus_start(); send_byte(8'h90, a); send_byte(8'h06, b); send_byte(8'hEE, c);
    bus_stop(); qwait();
    model[6] = 8'hEE;
    chk("R9 data ack after restart", 64'(c), 64'd1);
    chk("R9 regs", reg_flat, model_flat());

    // R9 with R3: foreign address then repeated START to this target
    bus_start(); send_byte(8'h92, a);
    bus_start(); send_byte(8'h90, b); send_byte(8'h01, c); send_byte(8'h99, d);
    bus_stop(); qwait();
    model[1] = 8'h99;
    chk("R3 foreign address nack", 64'(a), 64'd0);
    chk("R9 address ack after restart", 64'(b), 64'd1);
    chk("R9 regs after foreign", reg_flat, model_flat());

    // R10: STOP halfway through a data byte writes nothing
    s0 = stb_cnt;
    bus_start(); send_byte(8'h90, a); send_byte(8'h02, b);
    send_bit(1); send_bit(0); send_bit(1); send_bit(1);
    bus_stop(); qwait();
    chk("R10 truncated regs", reg_flat, model_flat());
    chk("R10 truncated strobes", 64'(stb_cnt - s0), 64'd0);
    chk("R10 sda released", 64'(sda_oe), 64'd0);
    bus_start(); send_byte(8'h90, a); send_byte(8'h02, b); send_byte(8'h3E, c);
    bus_stop(); qwait();
    model[2] = 8'h3E;
    chk("R10 write after stop", reg_flat, model_flat());

    // R11 and R12 from the port monitors
    chk("R11 sda_oe moved with scl high", 64'(oe_bad), 64'd0);
    chk("R12 strobe width", 64'(max_run), 64'd1);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: run did not complete");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule